// File: doc/BRIEF.md
# SECDED Memory Word Protector

This block sits between a client and a plain memory that stores 22-bit words. Each 16-bit word the client writes is widened with five Hamming check bits and one overall parity bit before it goes out to the memory. Each word read back is checked. A word with one flipped bit is repaired before it is returned. A word with two flipped bits is reported as unrepairable.

The memory read is combinational in the block's view: the address leaves on `mem_raddr` in the same cycle as `rd_en`, and the stored word comes back on `mem_rdata` in that cycle. One registered decode stage follows, so the data and the two error pulses appear one clock after the read request.

Every read that finds an error leaves a record in a small first-in first-out log. The record holds the word address and a flag that marks a double error. Software reads the oldest record at the head outputs and removes it with a pop strobe. A sticky flag reports records that were lost because the log was full.

Top module: `secded_guard`

## Requirements
- R1: On `wr_en`, `mem_we`, `mem_waddr` and `mem_wdata` follow in the same cycle. `mem_wdata` is a 22-bit codeword laid out as follows:
  - Codeword position p is bit p.
  - The 16 data bits sit in ascending order at positions 3, 5, 6, 7, 9 to 15 and 17 to 21.
  - Bit 2^k (k = 0 to 4) is the even parity of all positions 1 to 21 whose index has bit k set.
  - Bit 0 makes the parity of all 22 bits even.
- R2: `mem_re` and `mem_raddr` follow `rd_en` and `rd_addr` in the same cycle. `rd_valid` is high exactly in the cycle after each cycle with `rd_en` high, and `rd_data` is presented in that cycle.
- R3: A read of a word with no flipped bit returns the written data, with `corrected` and `uncorrectable` both low.
- R4: A read of a word with exactly one flipped bit at any of the 22 positions, bit 0 included, returns the written data with `corrected` high for one cycle.
- R5: A read of a word with exactly two flipped bits raises `uncorrectable` for one cycle, and `corrected` stays low.
- R6: `corrected` and `uncorrectable` are never high together, and neither is high without `rd_valid`.
- R7: Each read that raises either flag appends a record {address, double flag} to the log. The record is visible in the same cycle as the flag. `log_valid` is high while the log holds any record, and `log_addr`/`log_double` show the oldest record.
- R8: `log_pop` removes the oldest record at the clock edge. A pop while the log is empty has no effect. A pop and a new record in the same cycle both take effect.
- R9: When the log holds `LOG_DEPTH` records (default 8), a new error record is dropped, even if a pop happens in the same cycle. `log_overflow` then goes high and stays high until reset.
- R10: After reset, `rd_valid`, `corrected`, `uncorrectable`, `log_valid` and `log_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | 22 | Encoded codeword to store |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | 22 | Stored codeword returned by memory |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Corrected read data |
| corrected | output | 1 | Single error repaired on this result |
| uncorrectable | output | 1 | Double error found on this result |
| log_pop | input | 1 | Remove oldest log record |
| log_valid | output | 1 | Log holds at least one record |
| log_addr | output | ADDR_W | Address of oldest record |
| log_double | output | 1 | Oldest record was a double error |
| log_overflow | output | 1 | Sticky: a record was dropped |

## Verification
The bench builds the block with `ADDR_W` = 4 and `LOG_DEPTH` = 4.

With 16 words, random traffic keeps returning to words that were corrupted earlier, and writes to those words repair them. With only four log slots, the full-log state is easy to reach, both under random traffic and in a directed burst. That brings within reach the case where a new error arrives on a full log together with a pop.

A directed sweep flips each of the 22 codeword positions in turn, and double flips include the overall parity bit.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 16;
  localparam int HAM_W  = 5;
  localparam int CW_W   = DATA_W + HAM_W + 1;
  localparam int DIDX_W = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CW_W);
  localparam int HIDX_W = $clog2(HAM_W);

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [HAM_W-1:0]  syn_t;

  typedef enum logic [1:0] {
    CHK_CLEAN  = 2'd0,
    CHK_SINGLE = 2'd1,
    CHK_DOUBLE = 2'd2
  } chk_kind_e;

  typedef struct packed {
    data_t     data;
    chk_kind_e kind;
  } chk_t;

  // Positions 1, 2, 4, 8, 16 hold Hamming bits; position 0 holds overall parity.
  function automatic logic is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic cw_t scatter(input data_t d);
    cw_t cw;
    int  n;
    cw = '0;
    n  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[CIDX_W'(p)] = d[DIDX_W'(n)];
        n++;
      end
    end
    return cw;
  endfunction

  function automatic data_t gather(input cw_t cw);
    data_t d;
    int    n;
    d = '0;
    n = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_check_pos(p)) begin
        d[DIDX_W'(n)] = cw[CIDX_W'(p)];
        n++;
      end
    end
    return d;
  endfunction

  function automatic syn_t syndrome(input cw_t cw);
    syn_t s;
    s = '0;
    for (int k = 0; k < HAM_W; k++) begin
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) != 0) s[HIDX_W'(k)] ^= cw[CIDX_W'(p)];
      end
    end
    return s;
  endfunction

  function automatic cw_t secded_encode(input data_t d);
    cw_t  cw;
    logic par;
    cw = scatter(d);
    for (int k = 0; k < HAM_W; k++) begin
      par = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) != 0) par ^= cw[CIDX_W'(p)];
      end
      cw[CIDX_W'(1 << k)] = par;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic chk_t secded_check(input cw_t cw);
    chk_t r;
    syn_t s;
    logic odd;
    cw_t  fixed;
    s     = syndrome(cw);
    odd   = ^cw;
    fixed = cw;
    if (!odd && s == '0) begin
      r.kind = CHK_CLEAN;
    end else if (odd && int'(s) < CW_W) begin
      fixed[s] = ~fixed[s];
      r.kind   = CHK_SINGLE;
    end else begin
      r.kind = CHK_DOUBLE;
    end
    r.data = gather(fixed);
    return r;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  assign cw_o = secded_encode(data_i);
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output chk_kind_e         kind_o
);
  chk_t res;
  always_comb begin
    res    = secded_check(cw_i);
    data_o = res.data;
    kind_o = res.kind;
  end
endmodule

// File: rtl/secded_err_log.sv
module secded_err_log #(
  parameter  int AW    = 10,
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             dbl_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic             dbl_o,
  output logic             ovf_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] count_o
);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DEPTH-1:0] dbl_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (count != '0);
  assign drop_o  = push_i && full;

  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[wr_ptr] <= addr_i;
      dbl_q[wr_ptr]  <= dbl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop_o) ovf_o <= 1'b1;
    end
  end

  assign valid_o = (count != '0);
  assign addr_o  = addr_q[rd_ptr];
  assign dbl_o   = dbl_q[rd_ptr];
  assign count_o = count;

endmodule

// File: rtl/secded_guard.sv
module secded_guard
  import secded_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LOG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [CW_W-1:0]   mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [CW_W-1:0]   mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              corrected,
  output logic              uncorrectable,
  input  logic              log_pop,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr,
  output logic              log_double,
  output logic              log_overflow
);

  localparam int CNT_W = $clog2(LOG_DEPTH + 1);

  // Write path
  cw_t enc_cw;
  secded_encoder u_enc (.data_i(wr_data), .cw_o(enc_cw));

  assign mem_we    = wr_en;
  assign mem_waddr = wr_addr;
  assign mem_wdata = enc_cw;
  assign mem_re    = rd_en;
  assign mem_raddr = rd_addr;

  // Read path
  data_t     dec_data;
  chk_kind_e dec_kind;
  secded_decoder u_dec (.cw_i(mem_rdata), .data_o(dec_data), .kind_o(dec_kind));

  // Named events for the checker
  logic             err_single, err_double, log_push, log_drop;
  logic [CNT_W-1:0] log_count;

  assign err_single = rd_en && (dec_kind == CHK_SINGLE);
  assign err_double = rd_en && (dec_kind == CHK_DOUBLE);
  assign log_push   = err_single || err_double;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid      <= 1'b0;
      corrected     <= 1'b0;
      uncorrectable <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_valid      <= rd_en;
      corrected     <= err_single;
      uncorrectable <= err_double;
      if (rd_en) rd_data <= dec_data;
    end
  end

  secded_err_log #(.AW(ADDR_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (log_push),
    .addr_i  (rd_addr),
    .dbl_i   (err_double),
    .pop_i   (log_pop),
    .valid_o (log_valid),
    .addr_o  (log_addr),
    .dbl_o   (log_double),
    .ovf_o   (log_overflow),
    .drop_o  (log_drop),
    .count_o (log_count)
  );

endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk
  import secded_pkg::*;
#(
  parameter int LOG_DEPTH = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CW_W-1:0]  mem_wdata,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             corrected,
  input logic             uncorrectable,
  input logic             log_push,
  input logic             log_drop,
  input logic             log_valid,
  input logic             log_overflow,
  input logic [CNT_W-1:0] log_count
);

  p_encode_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (syndrome(mem_wdata) == '0 && (^mem_wdata) == 1'b0));

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(corrected && uncorrectable));

  p_flags_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (corrected || uncorrectable) |-> rd_valid);

  p_push_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    log_push |=> log_valid);

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(log_count) <= LOG_DEPTH);

  p_drop_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    log_drop |-> int'(log_count) == LOG_DEPTH);

  p_drop_sets_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    log_drop |=> log_overflow);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    log_overflow |=> log_overflow);

endmodule

bind secded_guard secded_guard_chk #(.LOG_DEPTH(LOG_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .mem_wdata     (mem_wdata),
  .rd_en         (rd_en),
  .rd_valid      (rd_valid),
  .corrected     (corrected),
  .uncorrectable (uncorrectable),
  .log_push      (log_push),
  .log_drop      (log_drop),
  .log_valid     (log_valid),
  .log_overflow  (log_overflow),
  .log_count     (log_count)
);

// File: tb/secded_guard_tb.sv
module secded_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int LOG_DEPTH  = 4;
  localparam int DW         = 16;
  localparam int CWW        = 22;
  localparam int WORDS      = 1 << ADDR_W;

  logic              clk, rst_n;
  logic              wr_en, rd_en, log_pop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DW-1:0]     wr_data;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [CWW-1:0]    mem_wdata, mem_rdata;
  logic              rd_valid, corrected, uncorrectable;
  logic [DW-1:0]     rd_data;
  logic              log_valid, log_double, log_overflow;
  logic [ADDR_W-1:0] log_addr;

  secded_guard #(.ADDR_W(ADDR_W), .LOG_DEPTH(LOG_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .corrected(corrected), .uncorrectable(uncorrectable),
    .log_pop(log_pop), .log_valid(log_valid), .log_addr(log_addr),
    .log_double(log_double), .log_overflow(log_overflow)
  );

  // Memory model, written only by the bench tasks
  logic [CWW-1:0] bmem [WORDS];
  assign mem_rdata = bmem[mem_raddr];

  logic [DW-1:0] shadow [WORDS];
  int            flips  [WORDS];
  int            lq_addr[$];
  bit            lq_dbl [$];
  bit            exp_ovf;
  int            n_chk, n_fail;
  bit            done;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference codeword: data placed in non-power-of-two slots, group parities, then overall parity
  function automatic logic [CWW-1:0] ref_encode(input logic [DW-1:0] d);
    logic [CWW-1:0] w;
    logic           acc;
    int             n;
    w = '0;
    n = 0;
    for (int pos = 3; pos < CWW; pos++)
      if ((pos & (pos - 1)) != 0) begin
        w[pos] = d[n];
        n++;
      end
    for (int j = 0; j < 5; j++) begin
      acc = 1'b0;
      for (int pos = 3; pos < CWW; pos++) if (pos[j]) acc ^= w[pos];
      w[1 << j] = acc;
    end
    w[0] = ^w;
    return w;
  endfunction

  task automatic check_log(input string tag);
    chk(log_valid == (lq_addr.size() > 0), {tag, " R7 log_valid"}, log_valid, lq_addr.size() > 0);
    if (lq_addr.size() > 0) begin
      chk(log_addr == ADDR_W'(lq_addr[0]), {tag, " R7 log_addr"}, log_addr, lq_addr[0]);
      chk(log_double == lq_dbl[0], {tag, " R7 log_double"}, log_double, lq_dbl[0]);
    end
    chk(log_overflow == exp_ovf, {tag, " R9 log_overflow"}, log_overflow, exp_ovf);
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    logic [CWW-1:0] cw;
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = d;
    #1;
    chk(mem_we && mem_waddr == ADDR_W'(a), "R1 write strobe/address", {mem_we, 27'b0, mem_waddr}, {1'b1, 27'b0, ADDR_W'(a)});
    chk(mem_wdata == ref_encode(d), "R1 codeword", mem_wdata, ref_encode(d));
    cw = mem_wdata;
    tick;
    wr_en     = 1'b0;
    bmem[a]   = cw;
    shadow[a] = d;
    flips[a]  = 0;
  endtask

  task automatic inject(input int a, input int b1, input int b2, input int nb);
    bmem[a][b1] = ~bmem[a][b1];
    if (nb == 2) bmem[a][b2] = ~bmem[a][b2];
    flips[a] = nb;
  endtask

  task automatic do_read(input int a, input bit pop);
    int k, s0;
    k       = flips[a];
    rd_en   = 1'b1;
    rd_addr = ADDR_W'(a);
    log_pop = pop;
    #1;
    chk(mem_re && mem_raddr == ADDR_W'(a), "R2 read strobe/address", {mem_re, 27'b0, mem_raddr}, {1'b1, 27'b0, ADDR_W'(a)});
    tick;
    rd_en   = 1'b0;
    log_pop = 1'b0;
    chk(rd_valid == 1'b1, "R2 rd_valid one cycle after rd_en", rd_valid, 1);
    if (k == 0) begin
      chk(rd_data == shadow[a], "R3 clean data", rd_data, shadow[a]);
      chk(!corrected && !uncorrectable, "R3 clean flags", {corrected, uncorrectable}, 0);
    end else if (k == 1) begin
      chk(rd_data == shadow[a], "R4 corrected data", rd_data, shadow[a]);
      chk(corrected && !uncorrectable, "R4 single flags", {corrected, uncorrectable}, 2);
    end else begin
      chk(uncorrectable && !corrected, "R5 double flags", {corrected, uncorrectable}, 1);
    end
    s0 = lq_addr.size();
    if (k != 0) begin
      if (s0 < LOG_DEPTH) begin
        lq_addr.push_back(a);
        lq_dbl.push_back(k == 2);
      end else begin
        exp_ovf = 1'b1;
      end
    end
    if (pop && s0 > 0) begin
      void'(lq_addr.pop_front());
      void'(lq_dbl.pop_front());
    end
    check_log("read");
  endtask

  task automatic do_pop;
    log_pop = 1'b1;
    tick;
    log_pop = 1'b0;
    chk(!rd_valid && !corrected && !uncorrectable, "R6 no result without read", {rd_valid, corrected, uncorrectable}, 0);
    if (lq_addr.size() > 0) begin
      void'(lq_addr.pop_front());
      void'(lq_dbl.pop_front());
    end
    check_log("R8 pop");
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int b2, a, op;
    n_chk = 0; n_fail = 0; done = 1'b0; exp_ovf = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; log_pop = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int i = 0; i < WORDS; i++) begin bmem[i] = '0; shadow[i] = '0; flips[i] = 0; end
    void'($urandom(32'h5EC0DE));
    tick; tick; tick;
    // R10 reset state
    chk(!rd_valid && !corrected && !uncorrectable, "R10 reset outputs", {rd_valid, corrected, uncorrectable}, 0);
    chk(!log_valid && !log_overflow, "R10 reset log", {log_valid, log_overflow}, 0);
    rst_n = 1'b1;
    tick;

    // R1 directed patterns, then fill
    do_write(0, 16'h0000);
    do_write(1, 16'hFFFF);
    do_write(2, 16'h0001);
    do_write(3, 16'h8000);
    do_write(4, 16'hA5C3);
    for (int i = 5; i < WORDS; i++) do_write(i, DW'($urandom));

    // R3 clean reads
    for (int i = 0; i < WORDS; i++) do_read(i, 1'b0);
    tick;
    chk(!rd_valid, "R2 valid drops after read", rd_valid, 0);

    // R4 sweep: every single position, with pop in the same cycle as the new record
    for (int b = 0; b < CWW; b++) begin
      inject(5, b, 0, 1);
      do_read(5, 1'b1);
      bmem[5][b] = ~bmem[5][b];
      flips[5] = 0;
    end
    while (lq_addr.size() > 0) do_pop();
    do_pop(); // R8 pop on empty log ignored

    // R5 doubles, including the overall parity bit
    inject(6, 0, 13, 2);  do_read(6, 1'b0);
    do_write(6, shadow[6]);
    inject(7, 1, 16, 2);  do_read(7, 1'b0);
    do_write(7, shadow[7]);
    inject(8, 20, 21, 2); do_read(8, 1'b1);
    do_write(8, shadow[8]);
    while (lq_addr.size() > 0) do_pop();

    // R9 fill the log, then overflow, then drop with simultaneous pop
    chk(!log_overflow, "R9 overflow low before fill", log_overflow, 0);
    for (int i = 0; i < LOG_DEPTH; i++) inject(i, i + 3, 0, 1);
    for (int i = 0; i < LOG_DEPTH; i++) do_read(i, 1'b0);
    chk(!log_overflow, "R9 overflow low when exactly full", log_overflow, 0);
    inject(LOG_DEPTH, 2, 9, 2);
    do_read(LOG_DEPTH, 1'b0);
    do_read(LOG_DEPTH, 1'b1);
    do_pop();
    chk(log_overflow, "R9 overflow sticky after pops", log_overflow, 1);
    for (int i = 0; i <= LOG_DEPTH; i++) do_write(i, shadow[i]);
    while (lq_addr.size() > 0) do_pop();

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      op = int'($urandom % 4);
      a  = int'($urandom % WORDS);
      case (op)
        0: do_write(a, DW'($urandom));
        1: if (flips[a] == 0) begin
             b2 = int'($urandom % CWW);
             inject(a, b2, (b2 + 1 + int'($urandom % (CWW - 1))) % CWW, 1 + int'($urandom % 2));
           end
        2: do_read(a, bit'($urandom % 2));
        default: do_pop();
      endcase
    end
    finish_run();
  end

endmodule